// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block decides, once per cycle, how many of the two oldest instructions in the issue window of an in-order core may leave together. Each slot brings a valid bit and a 4-bit decoded class code. The branch unit supplies a busy flag. The block applies class-specific rules that are not symmetric between the two slots. It then reports one of three outcomes: both instructions issue, only the older one issues, or neither issues. When the pair is refused, it also gives an encoded reason.

The decision is purely combinational. A single register stage with a stall input and a synchronous active-high reset holds the result. Every output therefore reflects the inputs sampled at the previous rising clock edge. Operand dependencies, long-latency unit hazards and forwarding are handled elsewhere.

Top module: `dual_issue_pair_check`

## Requirements
- R1: `issue_younger` is never 1 unless `issue_older` is 1 in the same cycle. When `older_valid` is 0, neither issues and the reason is 2 (older empty).
- R2: The branch class is code 0 (direct branch) and code 1 (call). When both slots hold a branch-class instruction, only the older one issues, with reason 8.
- R3: A direct branch (code 0) pairs with an immediate ALU op (code 2) whether the branch is the older or the younger instruction.
- R4: A call (code 1) in the older slot never pairs; the older one issues alone with reason 9. A call in the younger slot pairs with an older immediate ALU op.
- R5: An immediate ALU op (code 2) may take either slot, so two of them pair with reason 0.
- R6: A register ALU op (code 3) or shifted ALU op (code 4) in the older slot pairs only with a younger code 2; any other valid younger class gives reason 11. When code 3 or 4 sits in the younger slot, the older one issues alone with reason 10.
- R7: Single-issue classes are multiply (5), multi-word load/store (6), core-to-FP transfer (7), SIMD (8), and every code from 9 to 15 (15 being reserved). In the older slot such a class issues alone with reason 4. In the younger slot it leaves the older one to issue alone with reason 6.
- R8: When `younger_valid` is 0 and the older slot is valid and unblocked, the older one issues alone with reason 5.
- R9: While `branch_busy` is 1, an older branch-class instruction issues nothing, with reason 3. A younger branch-class instruction is refused, so the older one issues alone with reason 7.
- R10: When `stall` is 1 at a rising edge, both issue outputs become 0 with reason 1. Otherwise the outputs take the decision for the inputs at that edge. Reset gives 0, 0, reason 2.
- R11: When several refusals apply, the reason follows this order: stall (1), older empty (2), older branch busy (3), older single-issue (4), younger empty (5), younger single-issue (6), younger branch busy (7), two branches (8), call as older (9), younger register form (10), older needs immediate partner (11). Reason 0 means both issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Blocks all issue at this edge |
| older_valid | input | 1 | Older slot holds an instruction |
| older_class | input | 4 | Class code of the older instruction |
| younger_valid | input | 1 | Younger slot holds an instruction |
| younger_class | input | 4 | Class code of the younger instruction |
| branch_busy | input | 1 | Branch unit cannot accept a branch this cycle |
| issue_older | output | 1 | Older instruction issues (registered) |
| issue_younger | output | 1 | Younger instruction issues (registered) |
| refuse_reason | output | 4 | Why pairing was refused; 0 when both issue (registered) |

## Verification
The assertions check, on every cycle, the rules that do not depend on combinations of classes:
- the younger slot never issues without the older one;
- a stall empties the next outputs;
- two branch-class instructions, an older call and an older single-issue class never yield a pair;
- reason 0 appears exactly when both slots issue.

Only the directed scenarios can show that the legal pairs really do pair, as in branch with immediate ALU in both orders, register ALU followed by immediate ALU, and a younger call. They also establish the exact reason code that the priority order selects when several refusals overlap.

// File: rtl/dip_pkg.sv
package dip_pkg;

  localparam int CLASS_W  = 4;
  localparam int REASON_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CLS_BRANCH     = 4'd0,
    CLS_CALL       = 4'd1,
    CLS_ALU_IMM    = 4'd2,
    CLS_ALU_REG    = 4'd3,
    CLS_ALU_SHIFT  = 4'd4,
    CLS_MUL        = 4'd5,
    CLS_MEM_MULTI  = 4'd6,
    CLS_CORE_TO_FP = 4'd7,
    CLS_SIMD       = 4'd8,
    CLS_RESERVED   = 4'd15
  } op_class_e;

  typedef enum logic [REASON_W-1:0] {
    RSN_PAIRED          = 4'd0,
    RSN_STALLED         = 4'd1,
    RSN_OLDER_EMPTY     = 4'd2,
    RSN_OLDER_BR_BUSY   = 4'd3,
    RSN_OLDER_SOLO      = 4'd4,
    RSN_YOUNGER_EMPTY   = 4'd5,
    RSN_YOUNGER_SOLO    = 4'd6,
    RSN_YOUNGER_BR_BUSY = 4'd7,
    RSN_TWO_BRANCHES    = 4'd8,
    RSN_CALL_AS_OLDER   = 4'd9,
    RSN_YOUNGER_REGFORM = 4'd10,
    RSN_OLDER_NEEDS_IMM = 4'd11
  } reason_e;

  typedef struct packed {
    logic valid;
    logic is_branch;   // direct branch or call
    logic is_call;
    logic imm_alu;     // may take either slot
    logic reg_alu;     // register or shifted ALU form
    logic solo;        // occupies both slots
  } slot_attr_t;

endpackage

// File: rtl/dip_class_decode.sv
module dip_class_decode
  import dip_pkg::*;
#(
  parameter int CW = CLASS_W
) (
  input  logic          vld,
  input  logic [CW-1:0] cls,
  output slot_attr_t    attr
);

  localparam logic [CW-1:0] LAST_PAIRABLE = CW'(CLS_ALU_SHIFT);

  always_comb begin
    attr           = '0;
    attr.valid     = vld;
    attr.is_branch = (cls == CW'(CLS_BRANCH)) || (cls == CW'(CLS_CALL));
    attr.is_call   = (cls == CW'(CLS_CALL));
    attr.imm_alu   = (cls == CW'(CLS_ALU_IMM));
    attr.reg_alu   = (cls == CW'(CLS_ALU_REG)) || (cls == CW'(CLS_ALU_SHIFT));
    // every code past the last pairable class, reserved included, is solo
    attr.solo      = (cls > LAST_PAIRABLE);
  end

endmodule

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
  import dip_pkg::*;
(
  input  slot_attr_t older,
  input  slot_attr_t younger,
  input  logic       br_busy,
  output logic       go_older,
  output logic       go_younger,
  output reason_e    why
);

  always_comb begin
    go_older   = 1'b1;
    go_younger = 1'b0;
    why        = RSN_PAIRED;
    if (!older.valid) begin
      go_older = 1'b0;
      why      = RSN_OLDER_EMPTY;
    end else if (older.is_branch && br_busy) begin
      go_older = 1'b0;
      why      = RSN_OLDER_BR_BUSY;
    end else if (older.solo) begin
      why = RSN_OLDER_SOLO;
    end else if (!younger.valid) begin
      why = RSN_YOUNGER_EMPTY;
    end else if (younger.solo) begin
      why = RSN_YOUNGER_SOLO;
    end else if (younger.is_branch && br_busy) begin
      why = RSN_YOUNGER_BR_BUSY;
    end else if (older.is_branch && younger.is_branch) begin
      why = RSN_TWO_BRANCHES;
    end else if (older.is_call) begin
      why = RSN_CALL_AS_OLDER;
    end else if (younger.reg_alu) begin
      why = RSN_YOUNGER_REGFORM;
    end else if (older.reg_alu && !younger.imm_alu) begin
      why = RSN_OLDER_NEEDS_IMM;
    end else begin
      go_younger = 1'b1;
    end
  end

endmodule

// File: rtl/dip_issue_reg.sv
module dip_issue_reg
  import dip_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stall,
  input  logic    d_older,
  input  logic    d_younger,
  input  reason_e d_why,
  output logic    q_older,
  output logic    q_younger,
  output reason_e q_why
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_older   <= 1'b0;
      q_younger <= 1'b0;
      q_why     <= RSN_OLDER_EMPTY;
    end else if (stall) begin
      q_older   <= 1'b0;
      q_younger <= 1'b0;
      q_why     <= RSN_STALLED;
    end else begin
      q_older   <= d_older;
      q_younger <= d_younger;
      q_why     <= d_why;
    end
  end

  // R10: a stall at an edge leaves nothing issued after it
  a_r10_stall_empties: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!q_older && !q_younger && q_why == RSN_STALLED));

endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dip_pkg::*;
#(
  parameter int CW = CLASS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          older_valid,
  input  logic [CW-1:0] older_class,
  input  logic          younger_valid,
  input  logic [CW-1:0] younger_class,
  input  logic          branch_busy,
  output logic          issue_older,
  output logic          issue_younger,
  output logic [3:0]    refuse_reason
);

  localparam int N_SLOTS = 2;

  logic [N_SLOTS-1:0]         slot_vld;
  logic [N_SLOTS-1:0][CW-1:0] slot_cls;
  slot_attr_t                 slot_attr [N_SLOTS];

  assign slot_vld = {younger_valid, older_valid};
  assign slot_cls = {younger_class, older_class};

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    dip_class_decode #(.CW(CW)) dec_i (
      .vld  (slot_vld[s]),
      .cls  (slot_cls[s]),
      .attr (slot_attr[s])
    );
  end

  logic    dec_older, dec_younger;
  reason_e dec_why, reg_why;

  dip_pair_rules rules_i (
    .older      (slot_attr[0]),
    .younger    (slot_attr[1]),
    .br_busy    (branch_busy),
    .go_older   (dec_older),
    .go_younger (dec_younger),
    .why        (dec_why)
  );

  dip_issue_reg stage_i (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .d_older   (dec_older),
    .d_younger (dec_younger),
    .d_why     (dec_why),
    .q_older   (issue_older),
    .q_younger (issue_younger),
    .q_why     (reg_why)
  );

  assign refuse_reason = reg_why;

  // R1: the second slot never goes without the first
  a_r1_younger_needs_older: assert property (@(posedge clk) disable iff (rst)
    issue_younger |-> issue_older);

  // R2: two branch-class ops never leave together
  a_r2_no_branch_pair: assert property (@(posedge clk) disable iff (rst)
    (older_class <= CW'(CLS_CALL) && younger_class <= CW'(CLS_CALL))
      |=> !issue_younger);

  // R4: a call in the older slot never pairs
  a_r4_call_not_older: assert property (@(posedge clk) disable iff (rst)
    (older_class == CW'(CLS_CALL)) |=> !issue_younger);

  // R7: single-issue classes in the older slot never pair
  a_r7_older_solo: assert property (@(posedge clk) disable iff (rst)
    (older_class > CW'(CLS_ALU_SHIFT)) |=> !issue_younger);

  // R11: reason 0 is reported exactly when both slots issued
  a_r11_paired_code: assert property (@(posedge clk) disable iff (rst)
    (refuse_reason == 4'd0) == issue_younger);

endmodule

// File: tb/dual_issue_pair_check_tb_top.sv
module dual_issue_pair_check_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stall = 1'b0;
  logic       older_valid = 1'b0;
  logic [3:0] older_class = 4'd0;
  logic       younger_valid = 1'b0;
  logic [3:0] younger_class = 4'd0;
  logic       branch_busy = 1'b0;
  logic       issue_older, issue_younger;
  logic [3:0] refuse_reason;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_pair_check dut_i (
    .clk(clk), .rst(rst), .stall(stall),
    .older_valid(older_valid), .older_class(older_class),
    .younger_valid(younger_valid), .younger_class(younger_class),
    .branch_busy(branch_busy),
    .issue_older(issue_older), .issue_younger(issue_younger),
    .refuse_reason(refuse_reason)
  );

  task automatic check_out(input logic eo, input logic ey, input logic [3:0] er,
                           input string tag);
    n_checks++;
    if (issue_older !== eo || issue_younger !== ey || refuse_reason !== er) begin
      n_fails++;
      $display("FAIL %s: got older=%b younger=%b reason=%0d, expected older=%b younger=%b reason=%0d",
               tag, issue_older, issue_younger, refuse_reason, eo, ey, er);
    end
  endtask

  // inputs set at a falling edge; result checked one falling edge later
  task automatic step(input logic ov, input logic [3:0] oc, input logic yv,
                      input logic [3:0] yc, input logic bb, input logic st,
                      input logic eo, input logic ey, input logic [3:0] er,
                      input string tag);
    older_valid = ov; older_class = oc;
    younger_valid = yv; younger_class = yc;
    branch_busy = bb; stall = st;
    @(negedge clk);
    check_out(eo, ey, er, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_out(1'b0, 1'b0, 4'd2, "R10 reset state");
    rst = 1'b0;
  endtask

  task automatic t_imm_pairs();
    step(1, 4'd2, 1, 4'd2, 0, 0, 1, 1, 4'd0, "R5 imm+imm");
  endtask

  task automatic t_direct_branch();
    step(1, 4'd0, 1, 4'd2, 0, 0, 1, 1, 4'd0, "R3 branch older");
    step(1, 4'd2, 1, 4'd0, 0, 0, 1, 1, 4'd0, "R3 branch younger");
  endtask

  task automatic t_call();
    step(1, 4'd1, 1, 4'd2, 0, 0, 1, 0, 4'd9, "R4 call older");
    step(1, 4'd2, 1, 4'd1, 0, 0, 1, 1, 4'd0, "R4 call younger");
  endtask

  task automatic t_two_branches();
    step(1, 4'd0, 1, 4'd1, 0, 0, 1, 0, 4'd8, "R2 branch+call");
    step(1, 4'd1, 1, 4'd0, 0, 0, 1, 0, 4'd8, "R2 call+branch");
    step(1, 4'd0, 1, 4'd0, 0, 0, 1, 0, 4'd8, "R2 branch+branch");
  endtask

  task automatic t_reg_forms();
    step(1, 4'd3, 1, 4'd2, 0, 0, 1, 1, 4'd0, "R6 reg+imm");
    step(1, 4'd4, 1, 4'd2, 0, 0, 1, 1, 4'd0, "R6 shift+imm");
    step(1, 4'd3, 1, 4'd0, 0, 0, 1, 0, 4'd11, "R6 reg+branch");
    step(1, 4'd2, 1, 4'd4, 0, 0, 1, 0, 4'd10, "R6 imm+shift");
    step(1, 4'd3, 1, 4'd3, 0, 0, 1, 0, 4'd10, "R6 reg+reg");
  endtask

  task automatic t_solo();
    for (int c = 5; c < 16; c++) begin
      step(1, 4'(c), 1, 4'd2, 0, 0, 1, 0, 4'd4, "R7 older solo");
      step(1, 4'd2, 1, 4'(c), 0, 0, 1, 0, 4'd6, "R7 younger solo");
    end
  endtask

  task automatic t_empty_slots();
    step(1, 4'd3, 0, 4'd2, 0, 0, 1, 0, 4'd5, "R8 younger empty");
    step(0, 4'd2, 1, 4'd2, 0, 0, 0, 0, 4'd2, "R1 older empty");
  endtask

  task automatic t_branch_busy();
    step(1, 4'd0, 1, 4'd2, 1, 0, 0, 0, 4'd3, "R9 older branch busy");
    step(1, 4'd2, 1, 4'd1, 1, 0, 1, 0, 4'd7, "R9 younger call busy");
    step(1, 4'd2, 1, 4'd2, 1, 0, 1, 1, 4'd0, "R9 busy no branch");
  endtask

  task automatic t_stall_priority();
    step(1, 4'd2, 1, 4'd2, 0, 1, 0, 0, 4'd1, "R10 stall");
    step(0, 4'd0, 0, 4'd0, 1, 1, 0, 0, 4'd1, "R11 stall over empty");
    step(0, 4'd0, 1, 4'd0, 1, 0, 0, 0, 4'd2, "R11 empty over busy");
    step(1, 4'd0, 1, 4'd7, 1, 0, 0, 0, 4'd3, "R11 busy over solo");
    step(1, 4'd6, 0, 4'd0, 0, 0, 1, 0, 4'd4, "R11 solo over younger empty");
    step(1, 4'd1, 1, 4'd8, 0, 0, 1, 0, 4'd6, "R11 younger solo over call");
    step(1, 4'd1, 1, 4'd0, 1, 0, 0, 0, 4'd3, "R11 older busy first");
    step(1, 4'd1, 1, 4'd3, 0, 0, 1, 0, 4'd9, "R11 call over regform");
    step(1, 4'd2, 1, 4'd2, 0, 0, 1, 1, 4'd0, "R10 resumes after stall");
  endtask

  task automatic t_midrun_reset();
    older_valid = 1; older_class = 4'd2; younger_valid = 1; younger_class = 4'd2;
    rst = 1'b1;
    @(negedge clk);
    check_out(1'b0, 1'b0, 4'd2, "R10 reset mid-run");
    rst = 1'b0;
    @(negedge clk);
    check_out(1'b1, 1'b1, 4'd0, "R10 after reset");
  endtask

  initial begin
    t_reset();
    t_imm_pairs();
    t_direct_branch();
    t_call();
    t_two_branches();
    t_reg_forms();
    t_solo();
    t_empty_slots();
    t_branch_busy();
    t_stall_priority();
    t_midrun_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule